// File: doc/BRIEF.md
# Clock-Gate and Peripheral-Reset Register Bank

This block holds the clock-enable bits and the reset-assert bits for a set of peripheral groups. Each group has two write addresses. A write to the first address turns on every bit that is 1 in the data word. A write to the second address turns off every bit that is 1 in the data word. Software can therefore change any single bit with one store and never needs a read-modify-write sequence. The register state drives the `ena_o` and `rst_o` output vectors directly. The gating cells and the reset synchronisers that use these vectors sit outside this block.

A key register at offset 0x0 guards the reset groups. While the key is locked, writes to any reset group are dropped. The enable groups can be written at any time. Accesses take one cycle. A write is taken on the rising clock edge while `we_i` is high, and read data is a combinational function of `addr_i`.

Top module: `cgr_bank`

## Requirements
- R1: After reset, every enable group reads all ones over its width, every reset group reads all ones over its width with bit 0 cleared (bit 0 of each reset group is its core or bus-fabric reset and comes out of reset released), and the key is locked.
- R2: A write to enable group g at byte address 0x60 + 12·g sets the group bits whose data bit is 1 and leaves all other bits unchanged; `ena_o[g]` shows the new value from the next clock edge.
- R3: A write to enable group g at its base address + 4 clears the group bits whose data bit is 1 and leaves all other bits unchanged.
- R4: While the key is unlocked, a write to reset group g at byte address 0x1C + 8·g asserts the reset bits whose data bit is 1 and leaves all other bits unchanged.
- R5: While the key is unlocked, a write to reset group g at its base address + 4 releases the reset bits whose data bit is 1 and leaves all other bits unchanged.
- R6: Writing 0x00A50001 to address 0x0 unlocks the key, writing 0x00A50000 locks it, and any other value leaves it unchanged. A read of 0x0 returns 0x00A50000 with bit 0 set when the key is unlocked.
- R7: While the key is locked, writes to any reset-group address leave the reset state unchanged, and enable-group writes still take effect.
- R8: A read of a group's base address and a read of its base + 4 both return that group's current state, zero-extended to 32 bits.
- R9: Writes to unmapped addresses change no state, and reads from them return zero. Unmapped addresses include base + 8 of an enable group and any address that is not 4-byte aligned.
- R10: The enable group widths are 2, 7, 4, 8, 3, 14, 21, 6 and 19 bits for g = 0..8. The reset group widths are 2, 5, 3, 5, 3, 11, 12 and 5 bits for g = 0..7. Data bits above a group's width have no effect and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address of the access |
| wdata_i | input | 32 | Write data or bit mask |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| ena_o | output | 9×32 | Clock-enable state per group, zero above group width |
| rst_o | output | 8×32 | Reset-assert state per group, zero above group width |

## Verification
The assertions check the following on every cycle: set and clear writes change exactly the masked bits, unmasked bits hold, reset state is frozen under a locked write, the key moves only on its two code values, at most one decoded target is selected, and an unmapped address reads zero. Only the bench scenarios can show that the right group responds to the right address and that the reset values are correct. The same applies to the group widths, to base+4 readback matching base readback, and to the lock and unlock sequence over many writes. Those scenarios mix random traffic with directed cases: locked writes, invalid key values, gap and unaligned addresses, and masks wider than the group.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

  localparam int ENA_GROUPS = 9;
  localparam int RST_GROUPS = 8;

  function automatic int ena_width(input int g);
    case (g)
      0: return 2;
      1: return 7;
      2: return 4;
      3: return 8;
      4: return 3;
      5: return 14;
      6: return 21;
      7: return 6;
      8: return 19;
      default: return 32;
    endcase
  endfunction

  function automatic int rst_width(input int g);
    case (g)
      0: return 2;
      1: return 5;
      2: return 3;
      3: return 5;
      4: return 3;
      5: return 11;
      6: return 12;
      7: return 5;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/cgr_decode.sv
module cgr_decode #(
  parameter int ADDR_W     = 8,
  parameter int ENA_N      = 9,
  parameter int RST_N      = 8,
  parameter int ENA_BASE   = 'h60,
  parameter int ENA_STEP   = 12,
  parameter int RST_BASE   = 'h1C,
  parameter int RST_STEP   = 8,
  parameter int KEY_ADDR   = 'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ENA_N-1:0]  ena_set_o,
  output logic [ENA_N-1:0]  ena_clr_o,
  output logic [RST_N-1:0]  rst_set_o,
  output logic [RST_N-1:0]  rst_clr_o,
  output logic              key_o,
  output logic              hit_o
);

  for (genvar g = 0; g < ENA_N; g++) begin : g_ena
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(ENA_BASE + g * ENA_STEP);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(ENA_BASE + g * ENA_STEP + 4);
    assign ena_set_o[g] = (addr_i == SET_A);
    assign ena_clr_o[g] = (addr_i == CLR_A);
  end

  for (genvar g = 0; g < RST_N; g++) begin : g_rst
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(RST_BASE + g * RST_STEP);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(RST_BASE + g * RST_STEP + 4);
    assign rst_set_o[g] = (addr_i == SET_A);
    assign rst_clr_o[g] = (addr_i == CLR_A);
  end

  assign key_o = (addr_i == ADDR_W'(KEY_ADDR));
  assign hit_o = key_o | (|ena_set_o) | (|ena_clr_o) | (|rst_set_o) | (|rst_clr_o);

  // R9: the address map has no overlaps
  a_r9_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({key_o, ena_set_o, ena_clr_o, rst_set_o, rst_clr_o}));

endmodule

// File: rtl/cgr_key.sv
module cgr_key #(
  parameter int                 DATA_W = 32,
  parameter logic [DATA_W-1:0]  UNLOCK = 32'h00A5_0001,
  parameter logic [DATA_W-1:0]  LOCK   = 32'h00A5_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           unlocked_o <= 1'b0;
    else if (wr_i && wdata_i == UNLOCK)    unlocked_o <= 1'b1;
    else if (wr_i && wdata_i == LOCK)      unlocked_o <= 1'b0;
  end

  a_r6_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == UNLOCK) |=> unlocked_o);
  a_r6_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == LOCK) |=> !unlocked_o);
  a_r6_other_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (wdata_i == UNLOCK || wdata_i == LOCK)) |=> $stable(unlocked_o));

endmodule

// File: rtl/cgr_sc_reg.sv
module cgr_sc_reg #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             allow_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  q_o <= INIT;
    else if (allow_i && set_i)    q_o <= q_o | mask_i;
    else if (allow_i && clr_i)    q_o <= q_o & ~mask_i;
  end

  // R2/R4: set writes raise every masked bit
  a_r2_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (allow_i && set_i) |=> ((q_o & $past(mask_i)) == $past(mask_i)));
  // R3/R5: clear writes drop every masked bit
  a_r3_clear_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (allow_i && clr_i && !set_i) |=> ((q_o & $past(mask_i)) == '0));
  // R2/R3: unmasked bits never move
  a_r2_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((q_o ^ $past(q_o)) & ~$past(mask_i)) == '0));
  // R7: no change without permission
  a_r7_blocked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow_i |=> $stable(q_o));

endmodule

// File: rtl/cgr_bank.sv
module cgr_bank #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int ENA_N    = cgr_pkg::ENA_GROUPS,
  parameter int RST_N    = cgr_pkg::RST_GROUPS,
  parameter int ENA_BASE = 'h60,
  parameter int ENA_STEP = 12,
  parameter int RST_BASE = 'h1C,
  parameter int RST_STEP = 8,
  parameter int KEY_ADDR = 'h0,
  parameter logic [DATA_W-1:0] KEY_OPEN  = 32'h00A5_0001,
  parameter logic [DATA_W-1:0] KEY_CLOSE = 32'h00A5_0000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic                          we_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [ENA_N-1:0][DATA_W-1:0]  ena_o,
  output logic [RST_N-1:0][DATA_W-1:0]  rst_o
);

  logic [ENA_N-1:0] ena_set, ena_clr;
  logic [RST_N-1:0] rst_set, rst_clr;
  logic             key_hit, any_hit, unlocked;

  cgr_decode #(
    .ADDR_W(ADDR_W), .ENA_N(ENA_N), .RST_N(RST_N),
    .ENA_BASE(ENA_BASE), .ENA_STEP(ENA_STEP),
    .RST_BASE(RST_BASE), .RST_STEP(RST_STEP), .KEY_ADDR(KEY_ADDR)
  ) i_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .ena_set_o (ena_set),
    .ena_clr_o (ena_clr),
    .rst_set_o (rst_set),
    .rst_clr_o (rst_clr),
    .key_o     (key_hit),
    .hit_o     (any_hit)
  );

  cgr_key #(.DATA_W(DATA_W), .UNLOCK(KEY_OPEN), .LOCK(KEY_CLOSE)) i_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (we_i & key_hit),
    .wdata_i    (wdata_i),
    .unlocked_o (unlocked)
  );

  for (genvar g = 0; g < ENA_N; g++) begin : g_ena
    localparam int W = cgr_pkg::ena_width(g);
    logic [W-1:0] q;
    cgr_sc_reg #(.WIDTH(W), .INIT({W{1'b1}})) i_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (we_i & ena_set[g]),
      .clr_i   (we_i & ena_clr[g]),
      .allow_i (1'b1),
      .mask_i  (wdata_i[W-1:0]),
      .q_o     (q)
    );
    assign ena_o[g] = DATA_W'(q);
  end

  for (genvar g = 0; g < RST_N; g++) begin : g_rst
    localparam int W = cgr_pkg::rst_width(g);
    logic [W-1:0] q;
    // bit 0 of each group (core / fabric) leaves reset released
    cgr_sc_reg #(.WIDTH(W), .INIT({{(W-1){1'b1}}, 1'b0})) i_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (we_i & rst_set[g]),
      .clr_i   (we_i & rst_clr[g]),
      .allow_i (unlocked),
      .mask_i  (wdata_i[W-1:0]),
      .q_o     (q)
    );
    assign rst_o[g] = DATA_W'(q);
  end

  always_comb begin
    rdata_o = '0;
    if (key_hit) rdata_o = KEY_CLOSE | DATA_W'(unlocked);
    for (int g = 0; g < ENA_N; g++)
      if (ena_set[g] || ena_clr[g]) rdata_o = ena_o[g];
    for (int g = 0; g < RST_N; g++)
      if (rst_set[g] || rst_clr[g]) rdata_o = rst_o[g];
  end

  a_r7_locked_reset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !unlocked && ((|rst_set) || (|rst_clr))) |=> (rst_o == $past(rst_o)));
  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_hit |-> (rdata_o == '0));
  a_r9_unmapped_write_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !any_hit) |=> ($stable(ena_o) && $stable(rst_o)));

endmodule

// File: tb/test_cgr_bank.sv
module test_cgr_bank;

  localparam int NE = 9;
  localparam int NR = 8;
  localparam logic [31:0] OPEN  = 32'h00A5_0001;
  localparam logic [31:0] CLOSE = 32'h00A5_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic              we = 1'b0;
  logic [31:0]       rdata;
  logic [NE-1:0][31:0] ena;
  logic [NR-1:0][31:0] rst;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [31:0] ena_m [NE];
  logic [31:0] rst_m [NR];
  logic        unl_m;

  always #2 clk = ~clk;

  cgr_bank i_cgr_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .ena_o(ena), .rst_o(rst)
  );

  function automatic int ew(int g);
    int t [NE] = '{2, 7, 4, 8, 3, 14, 21, 6, 19};
    return t[g];
  endfunction
  function automatic int rw(int g);
    int t [NR] = '{2, 5, 3, 5, 3, 11, 12, 5};
    return t[g];
  endfunction
  function automatic logic [31:0] wm(int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    if (a == 8'h00) return CLOSE | {31'b0, unl_m};
    for (int g = 0; g < NE; g++)
      if (a == 8'(8'h60 + 12 * g) || a == 8'(8'h64 + 12 * g)) return ena_m[g];
    for (int g = 0; g < NR; g++)
      if (a == 8'(8'h1C + 8 * g) || a == 8'(8'h20 + 8 * g)) return rst_m[g];
    return 32'h0;
  endfunction

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    if (a == 8'h00) begin
      if (d == OPEN) unl_m = 1'b1;
      else if (d == CLOSE) unl_m = 1'b0;
    end
    for (int g = 0; g < NE; g++) begin
      if (a == 8'(8'h60 + 12 * g)) ena_m[g] = ena_m[g] | (d & wm(ew(g)));
      if (a == 8'(8'h64 + 12 * g)) ena_m[g] = ena_m[g] & ~(d & wm(ew(g)));
    end
    if (unl_m && a != 8'h00)
      for (int g = 0; g < NR; g++) begin
        if (a == 8'(8'h1C + 8 * g)) rst_m[g] = rst_m[g] | (d & wm(rw(g)));
        if (a == 8'(8'h20 + 8 * g)) rst_m[g] = rst_m[g] & ~(d & wm(rw(g)));
      end
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_outputs(string req);
    for (int g = 0; g < NE; g++) chk(req, $sformatf("ena_o[%0d]", g), ena[g], ena_m[g]);
    for (int g = 0; g < NR; g++) chk(req, $sformatf("rst_o[%0d]", g), rst[g], rst_m[g]);
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] d, string req);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    model_write(a, d);
    chk_outputs(req);
  endtask

  task automatic do_read(logic [7:0] a, string req);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1;
    chk(req, $sformatf("rdata@%h", a), rdata, exp_read(a));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h0C6B_A5E1));
    for (int g = 0; g < NE; g++) ena_m[g] = wm(ew(g));
    for (int g = 0; g < NR; g++) rst_m[g] = wm(rw(g)) & ~32'h1;
    unl_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "ena_o[8]", ena[8], 32'h0007_FFFF);
    chk("R1", "rst_o[6]", rst[6], 32'h0000_0FFE);
    chk_outputs("R1");
    do_read(8'h00, "R1");

    // R7 locked: reset writes dropped, enable writes accepted
    do_write(8'h1C, 32'hFFFF_FFFF, "R7");
    chk("R7", "rst_o[0] locked", rst[0], 32'h2);
    do_write(8'h64, 32'h1, "R7");
    chk("R7", "ena_o[0] while locked", ena[0], 32'h2);

    // R6 key codes
    do_write(8'h00, 32'h00A5_0002, "R6");
    do_read(8'h00, "R6");
    do_write(8'h00, OPEN, "R6");
    chk("R6", "key read", exp_read(8'h00), 32'h00A5_0001);
    do_read(8'h00, "R6");

    // R4 / R5
    do_write(8'h1C, 32'h1, "R4");
    chk("R4", "rst_o[0] assert", rst[0], 32'h3);
    do_write(8'h20, 32'h3, "R5");
    chk("R5", "rst_o[0] release", rst[0], 32'h0);
    do_write(8'h54, 32'h1F, "R4");

    // R2 / R3 / R10 width masking on widest enable group
    do_write(8'h7C, 32'hFFFF_FFFF, "R3");
    do_write(8'h78, 32'hFFFF_FFF5, "R10");
    chk("R10", "ena_o[2] masked", ena[2], 32'h5);
    do_write(8'hA8, 32'hFFFF_FFFF, "R10");
    chk("R10", "ena_o[6] width", ena[6], 32'h001F_FFFF);

    // R8 both addresses read back
    do_read(8'h78, "R8");
    do_read(8'h7C, "R8");
    do_read(8'h4C, "R8");
    do_read(8'h50, "R8");

    // R9 gap, unaligned, out of range
    do_write(8'h64, 32'h3, "R3");
    do_write(8'h68, 32'hFFFF_FFFF, "R9");
    chk("R9", "ena_o[0] after gap write", ena[0], 32'h0);
    do_write(8'h61, 32'hFFFF_FFFF, "R9");
    do_read(8'h68, "R9");
    do_read(8'h61, "R9");
    do_read(8'hFC, "R9");

    // R7 relock then reset write dropped
    do_write(8'h00, CLOSE, "R6");
    do_write(8'h20, 32'hFFFF_FFFF, "R7");

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      int g;
      int k;
      logic [31:0] d;
      logic [7:0]  a;
      string tag;
      k = int'($urandom % 6);
      d = $urandom;
      case (k)
        0: begin
          case ($urandom % 3)
            0: d = OPEN;
            1: d = CLOSE;
            default: ;
          endcase
          a = 8'h00; tag = "R6";
        end
        1: begin g = int'($urandom % NE); a = 8'(8'h60 + 12 * g); tag = "R2"; end
        2: begin g = int'($urandom % NE); a = 8'(8'h64 + 12 * g); tag = "R3"; end
        3: begin g = int'($urandom % NR); a = 8'(8'h1C + 8 * g); tag = unl_m ? "R4" : "R7"; end
        4: begin g = int'($urandom % NR); a = 8'(8'h20 + 8 * g); tag = unl_m ? "R5" : "R7"; end
        default: begin a = 8'($urandom); tag = "R9"; end
      endcase
      do_write(a, d, tag);
      do_read(8'($urandom), "R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule